// File: doc/BRIEF.md
# ADC Conversion Sequencer with Byte Register Port

This block controls a multiplexed analog-to-digital converter through a small byte-wide register space. Software sets the input channel, a settle-delay code, an averaging count and the digital-parameter fields, sets the enable bit and then sets the request bit. The block latches the channel and drives it to the analog multiplexer. It waits out the settle delay, which is counted in microseconds. It then draws the requested number of samples from a request/valid converter port, averages them, stores a 16-bit result and signals completion with a status bit and a one-cycle interrupt.

The meaning of the settle-delay code depends on the digital revision of the block. The revision is fixed by parameters and can be read back. From revision 5.3 the upper eight codes select delays in milliseconds that double at each step. Earlier revisions use a flatter set of values for those codes. A converter error during sampling, or a request made while the block is disabled, raises a fault flag in place of a result.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, status (0x08) reads 0x00, both result bytes read 0x00, the enable register 0x46 reads 0x00, and `irq` and `conv_req` are low.
- R2: Address 0x00 returns the minor revision and 0x01 the major revision. The newer settle table is used when the revision is 5.3 or later.
- R3: Writable fields read back through their masks: 0x40 bits 3:0 (device select); 0x42 bit 6 (calibration value), bits 5:4 (calibration method), bits 3:2 (decimation); 0x43 bit 7 (average enable) and bits 2:0 (count code); 0x44 all eight bits (channel); 0x45 bits 3:0 (settle code); 0x46 bit 7 (enable). Address 0x47 and unmapped addresses read 0x00.
- R4: With the newer table, settle code c gives T = 15 µs for c = 0, T = 100·c µs for c = 1..7, and T = 1000·2^(c−8) µs for c = 8..15. `conv_req` first rises T·US_DIV + 1 cycles after the clock edge that accepts the request write.
- R5: With the older table, codes 0..7 match R4, and codes 8..15 give 800, 900, 1000, 2000, 4000, 6000, 8000 and 10000 µs.
- R6: When 0x43 bit 7 is set, a conversion takes 2^N samples, where N is 0x43 bits 2:0, and stores floor(sum/2^N). When bit 7 is clear, it takes one sample and stores it unchanged.
- R7: The result reads as its low byte at 0x50 and its high byte at 0x51.
- R8: Status bit 1 (pending) is set from the accepted request until the conversion ends. Status bit 0 (end of conversion) is set when a result is stored, so a finished conversion reads bits 1:0 = 01. A new accepted request clears bit 0.
- R9: `irq` is high for exactly one cycle, in the same cycle that end of conversion (or a fault) becomes visible.
- R10: A request (0x47 bit 7 written as 1) while 0x46 bit 7 is clear sets status bit 7 (fault). It samples nothing, leaves the result unchanged and pulses `irq`.
- R11: `conv_err` high during sampling ends the conversion with status 0x80 and leaves the result unchanged. When the error comes with the final sample, the fault still wins.
- R12: A request written while a conversion is pending is ignored: the settle timing of the running conversion is not restarted.
- R13: `conv_chan` takes the value of 0x44 when a request is accepted and holds it while later writes to 0x44 change only the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_re | input | 1 | Read strobe; data returns on the next cycle |
| bus_rdata | output | 8 | Registered read data |
| conv_req | output | 1 | High while samples are wanted |
| conv_chan | output | 8 | Latched multiplexer channel |
| conv_valid | input | 1 | Sample present on conv_data this cycle |
| conv_data | input | DATA_W | Converter sample |
| conv_err | input | 1 | Converter error flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge: the converter flags an error, and the final sample of an averaging run arrives. The stub raises the error flag exactly on sample index 2^N−1. The bench then expects status 0x80 and the previous result in 0x50/0x51, with no new average stored. A second overlap is a repeated request during the settle wait. It is judged by counting cycles from the first request to the rise of `conv_req`, which must match the unrestarted delay.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

   localparam logic [7:0] A_REV_MIN = 8'h00;
   localparam logic [7:0] A_REV_MAJ = 8'h01;
   localparam logic [7:0] A_STAT    = 8'h08;
   localparam logic [7:0] A_SID     = 8'h40;
   localparam logic [7:0] A_DIG     = 8'h42;
   localparam logic [7:0] A_AVG     = 8'h43;
   localparam logic [7:0] A_CHAN    = 8'h44;
   localparam logic [7:0] A_SETL    = 8'h45;
   localparam logic [7:0] A_EN      = 8'h46;
   localparam logic [7:0] A_REQ     = 8'h47;
   localparam logic [7:0] A_RES_LO  = 8'h50;
   localparam logic [7:0] A_RES_HI  = 8'h51;

   localparam int US_W      = 17;   // holds the longest delay in microseconds
   localparam int AVG_LOG2  = 7;    // up to 128 samples
   localparam int AVG_NW    = 3;

   typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_SAMPLE} seq_state_e;

   typedef struct packed {
      logic [7:0]        chan;
      logic [3:0]        settle;
      logic              adc_en;
      logic              avg_en;
      logic [AVG_NW-1:0] avg_n;
   } cfg_t;

   // Settle delay in microseconds for a code; newer selects the revised table.
   function automatic logic [US_W-1:0] settle_us(input logic [3:0] code, input logic newer);
      logic [US_W-1:0] v;
      if (code < 4'd8) begin
         v = (code == 4'd0) ? US_W'(15) : US_W'(code) * US_W'(100);
      end else if (newer) begin
         v = US_W'(1000) << (code - 4'd8);
      end else begin
         case (code)
            4'd8:    v = US_W'(800);
            4'd9:    v = US_W'(900);
            4'd10:   v = US_W'(1000);
            4'd11:   v = US_W'(2000);
            4'd12:   v = US_W'(4000);
            4'd13:   v = US_W'(6000);
            4'd14:   v = US_W'(8000);
            default: v = US_W'(10000);
         endcase
      end
      return v;
   endfunction

endpackage

// File: rtl/adcc_regs.sv
module adcc_regs
   import adcc_pkg::*;
#(
   parameter int VER_MINOR = 3,
   parameter int VER_MAJOR = 5,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   input  logic              pend,
   input  logic              eoc,
   input  logic              fault,
   input  logic [DATA_W-1:0] result,
   output cfg_t              cfg_o,
   output logic              go_o
);

   logic [3:0]        sid_q;
   logic              calv_q;
   logic [1:0]        calm_q;
   logic [1:0]        dec_q;
   logic              aven_q;
   logic [AVG_NW-1:0] avn_q;
   logic [7:0]        chan_q;
   logic [3:0]        setl_q;
   logic              en_q;
   logic [15:0]       res16;
   logic [7:0]        rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sid_q  <= '0;
         calv_q <= 1'b0;
         calm_q <= '0;
         dec_q  <= '0;
         aven_q <= 1'b0;
         avn_q  <= '0;
         chan_q <= '0;
         setl_q <= '0;
         en_q   <= 1'b0;
      end else if (bus_we) begin
         case (bus_addr)
            A_SID:  sid_q  <= bus_wdata[3:0];
            A_DIG: begin
               calv_q <= bus_wdata[6];
               calm_q <= bus_wdata[5:4];
               dec_q  <= bus_wdata[3:2];
            end
            A_AVG: begin
               aven_q <= bus_wdata[7];
               avn_q  <= bus_wdata[AVG_NW-1:0];
            end
            A_CHAN: chan_q <= bus_wdata;
            A_SETL: setl_q <= bus_wdata[3:0];
            A_EN:   en_q   <= bus_wdata[7];
            default: ;
         endcase
      end
   end

   assign go_o = bus_we && (bus_addr == A_REQ) && bus_wdata[7];

   always_comb begin
      cfg_o.chan   = chan_q;
      cfg_o.settle = setl_q;
      cfg_o.adc_en = en_q;
      cfg_o.avg_en = aven_q;
      cfg_o.avg_n  = avn_q;
   end

   always_comb begin
      res16 = '0;
      res16[DATA_W-1:0] = result;
   end

   always_comb begin
      case (bus_addr)
         A_REV_MIN: rd_mux = 8'(VER_MINOR);
         A_REV_MAJ: rd_mux = 8'(VER_MAJOR);
         A_STAT:    rd_mux = {fault, 5'b0, pend, eoc};
         A_SID:     rd_mux = {4'b0, sid_q};
         A_DIG:     rd_mux = {1'b0, calv_q, calm_q, dec_q, 2'b0};
         A_AVG:     rd_mux = {aven_q, {(7-AVG_NW){1'b0}}, avn_q};
         A_CHAN:    rd_mux = chan_q;
         A_SETL:    rd_mux = {4'b0, setl_q};
         A_EN:      rd_mux = {en_q, 7'b0};
         A_RES_LO:  rd_mux = res16[7:0];
         A_RES_HI:  rd_mux = res16[15:8];
         default:   rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/adcc_settle.sv
module adcc_settle
   import adcc_pkg::*;
#(
   parameter int US_DIV  = 250,
   parameter bit USE_NEW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [3:0] code,
   output logic       done_o
);

   localparam int DIV_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(US_DIV - 1);

   logic [US_W-1:0]  target;
   logic [US_W-1:0]  left_q;
   logic [DIV_W-1:0] div_q;
   logic             run_q;

   generate
      if (USE_NEW) begin : g_tbl_new
         assign target = settle_us(code, 1'b1);
      end else begin : g_tbl_old
         assign target = settle_us(code, 1'b0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         div_q  <= '0;
         left_q <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start) begin
            run_q  <= 1'b1;
            div_q  <= '0;
            left_q <= target;
         end else if (run_q) begin
            if (div_q == DIV_LAST) begin
               div_q <= '0;
               if (left_q == US_W'(1)) begin
                  run_q  <= 1'b0;
                  done_o <= 1'b1;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/adcc_avg.sv
module adcc_avg
   import adcc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [DATA_W-1:0] data,
   input  logic [AVG_NW-1:0] n,
   output logic              last_o,
   output logic [DATA_W-1:0] mean_o
);

   localparam int ACC_W = DATA_W + AVG_LOG2;

   logic [ACC_W-1:0]    acc_q;
   logic [ACC_W-1:0]    sum;
   logic [AVG_LOG2-1:0] cnt_q;
   logic [AVG_LOG2:0]   need;

   assign sum    = acc_q + ACC_W'(data);
   assign mean_o = DATA_W'(sum >> n);
   assign need   = (AVG_LOG2 + 1)'(1) << n;
   assign last_o = ({1'b0, cnt_q} == (need - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         acc_q <= sum;
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
   import adcc_pkg::*;
#(
   parameter int US_DIV    = 250,
   parameter int VER_MINOR = 3,
   parameter int VER_MAJOR = 5,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   output logic              conv_req,
   output logic [7:0]        conv_chan,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              conv_err,
   output logic              irq
);

   localparam bit NEWER = (VER_MAJOR > 5) || ((VER_MAJOR == 5) && (VER_MINOR >= 3));

   if (US_DIV < 1) begin : g_bad_div
      $error("US_DIV must be at least 1");
   end
   if ((DATA_W < 8) || (DATA_W > 16)) begin : g_bad_width
      $error("DATA_W must lie between 8 and 16");
   end

   cfg_t              cfg;
   logic              go;
   logic              adc_en;
   logic              start_ok;
   logic              settle_done;
   logic              avg_last;
   logic [DATA_W-1:0] avg_mean;
   logic              take;
   seq_state_e        state_q;
   logic              pend_q, eoc_q, fault_q;
   logic [DATA_W-1:0] result_q;
   logic [AVG_NW-1:0] n_q;

   adcc_regs #(.VER_MINOR(VER_MINOR), .VER_MAJOR(VER_MAJOR), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pend(pend_q), .eoc(eoc_q), .fault(fault_q), .result(result_q),
      .cfg_o(cfg), .go_o(go)
   );

   assign adc_en   = cfg.adc_en;
   assign start_ok = go && (state_q == ST_IDLE) && adc_en;
   assign take     = (state_q == ST_SAMPLE) && conv_valid && !conv_err;
   assign conv_req = (state_q == ST_SAMPLE);

   adcc_settle #(.US_DIV(US_DIV), .USE_NEW(NEWER)) settle_i (
      .clk(clk), .rst_n(rst_n), .start(start_ok), .code(cfg.settle), .done_o(settle_done)
   );

   adcc_avg #(.DATA_W(DATA_W)) avg_i (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .take(take), .data(conv_data),
      .n(n_q), .last_o(avg_last), .mean_o(avg_mean)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pend_q    <= 1'b0;
         eoc_q     <= 1'b0;
         fault_q   <= 1'b0;
         irq       <= 1'b0;
         result_q  <= '0;
         conv_chan <= '0;
         n_q       <= '0;
      end else begin
         irq <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  eoc_q <= 1'b0;
                  if (adc_en) begin
                     state_q   <= ST_SETTLE;
                     pend_q    <= 1'b1;
                     fault_q   <= 1'b0;
                     conv_chan <= cfg.chan;
                     n_q       <= cfg.avg_en ? cfg.avg_n : '0;
                  end else begin
                     fault_q <= 1'b1;
                     irq     <= 1'b1;
                  end
               end
            end
            ST_SETTLE: begin
               if (settle_done) state_q <= ST_SAMPLE;
            end
            ST_SAMPLE: begin
               if (conv_err) begin
                  fault_q <= 1'b1;
                  pend_q  <= 1'b0;
                  irq     <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (conv_valid && avg_last) begin
                  result_q <= avg_mean;
                  eoc_q    <= 1'b1;
                  pend_q   <= 1'b0;
                  irq      <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adcc_checker.sv
module adcc_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pend,
   input logic              eoc,
   input logic              fault,
   input logic              irq,
   input logic              conv_req,
   input logic              go,
   input logic              en,
   input logic [DATA_W-1:0] result
);

   a_r8_pend_eoc_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend && eoc));

   a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   a_r9_eoc_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc) |-> irq);

   a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (eoc || fault));

   a_r10_disabled_request: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !en && !pend) |=> (fault && !pend && !conv_req));

   a_r11_fault_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $stable(result));

   a_r12_busy_request_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (go && pend && !conv_req) |=> pend);

   a_r6_sampling_only_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> pend);

endmodule

bind adc_conv_ctrl adcc_checker #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .pend(pend_q), .eoc(eoc_q), .fault(fault_q),
   .irq(irq), .conv_req(conv_req), .go(go), .en(adc_en), .result(result_q)
);

// File: tb/adc_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb_top;

   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0, wdata = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [7:0]  rdata_n, rdata_o, chan_n, chan_o;
   logic        req_n, req_o, irq_n, irq_o;
   logic        valid_n = 1'b0, err_n = 1'b0;
   logic [15:0] data_n = '0;

   int tests = 0, fails = 0;
   int sidx = 0, err_at = -1, base = 0, step = 1;

   always #2 clk = ~clk;

   adc_conv_ctrl #(.US_DIV(DIV), .VER_MINOR(3), .VER_MAJOR(5), .DATA_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_re(re),
      .bus_rdata(rdata_n), .conv_req(req_n), .conv_chan(chan_n), .conv_valid(valid_n),
      .conv_data(data_n), .conv_err(err_n), .irq(irq_n));

   adc_conv_ctrl #(.US_DIV(DIV), .VER_MINOR(2), .VER_MAJOR(5), .DATA_W(16)) dut_old_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we), .bus_re(re),
      .bus_rdata(rdata_o), .conv_req(req_o), .conv_chan(chan_o), .conv_valid(req_o),
      .conv_data(16'h1234), .conv_err(1'b0), .irq(irq_o));

   function automatic logic [15:0] val(int k);
      return 16'(base + k * step);
   endfunction

   function automatic int exp_us(int code, bit newer);
      if (code < 8) return (code == 0) ? 15 : code * 100;
      if (newer) return 1000 * (1 << (code - 8));
      case (code)
         8: return 800;   9: return 900;   10: return 1000; 11: return 2000;
         12: return 4000; 13: return 6000; 14: return 8000; default: return 10000;
      endcase
   endfunction

   // converter stub: one sample every other cycle while requested
   always @(negedge clk) begin
      if (!req_n || valid_n) begin
         valid_n = 1'b0;
         err_n   = 1'b0;
      end else begin
         valid_n = 1'b1;
         data_n  = val(sidx);
         err_n   = (sidx == err_at);
         sidx++;
      end
   end

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic chk_rng(string tag, int act, int lo, int hi);
      tests++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output int vn, output int vo);
      @(negedge clk); addr = a; re = 1'b1;
      @(negedge clk); re = 1'b0; vn = rdata_n; vo = rdata_o;
   endtask

   task automatic setup(logic [7:0] avg, logic [7:0] ch, logic [7:0] code);
      wr(8'h42, 8'h20);
      wr(8'h43, avg);
      wr(8'h44, ch);
      wr(8'h45, code);
      wr(8'h46, 8'h80);
   endtask

   task automatic wait_irq(output int seen);
      seen = 0;
      for (int i = 0; i < 4000 && !seen; i++) begin
         @(negedge clk);
         if (irq_n) seen = 1;
      end
   endtask

   task automatic read_result(output int res);
      int lo, hi, d;
      rd(8'h50, lo, d);
      rd(8'h51, hi, d);
      res = (hi << 8) | lo;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int vn, vo, seen, res, prev, c, cn, co, irqs, sum, expv;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", irq_n, 0);
      chk("R1 conv_req", req_n, 0);
      rd(8'h08, vn, vo); chk("R1 status", vn, 8'h00);
      rd(8'h46, vn, vo); chk("R1 enable", vn, 8'h00);
      read_result(res);  chk("R1 result", res, 0);

      // R2 revision
      rd(8'h00, vn, vo); chk("R2 minor new", vn, 3); chk("R2 minor old", vo, 2);
      rd(8'h01, vn, vo); chk("R2 major new", vn, 5); chk("R2 major old", vo, 5);

      // R3 readback masks
      wr(8'h40, 8'hFF); rd(8'h40, vn, vo); chk("R3 sid", vn, 8'h0F);
      wr(8'h40, 8'h36); rd(8'h40, vn, vo); chk("R3 sid low", vn, 8'h06);
      wr(8'h42, 8'hFF); rd(8'h42, vn, vo); chk("R3 dig", vn, 8'h7C);
      wr(8'h43, 8'hFF); rd(8'h43, vn, vo); chk("R3 avg", vn, 8'h87);
      wr(8'h44, 8'hA5); rd(8'h44, vn, vo); chk("R3 chan", vn, 8'hA5);
      wr(8'h45, 8'hFF); rd(8'h45, vn, vo); chk("R3 settle", vn, 8'h0F);
      wr(8'h46, 8'h7F); rd(8'h46, vn, vo); chk("R3 enable", vn, 8'h00);
      wr(8'h47, 8'h00); rd(8'h47, vn, vo); chk("R3 req reads zero", vn, 8'h00);
      rd(8'h30, vn, vo); chk("R3 unmapped", vn, 8'h00);

      // R10 request while disabled
      irqs = 0;
      wr(8'h47, 8'h80);
      if (irq_n) irqs++;
      c = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (irq_n) irqs++;
         if (req_n) c++;
      end
      chk("R10 no sampling", c, 0);
      chk("R10 irq pulses", irqs, 1);
      rd(8'h08, vn, vo); chk("R10 status fault", vn, 8'h80);
      read_result(res);  chk("R10 result unchanged", res, 0);

      // R4 / R5 settle sweep on both revisions
      base = 16'h0100; step = 1;
      for (int code = 0; code <= 10; code++) begin
         setup(8'h00, 8'(code), 8'(code));
         sidx = 0;
         wr(8'h47, 8'h80);
         c = 0; cn = -1; co = -1;
         while ((cn < 0 || co < 0) && c < 20000) begin
            @(negedge clk); c++;
            if (cn < 0 && req_n) cn = c;
            if (co < 0 && req_o) co = c;
         end
         chk_rng($sformatf("R4 settle code %0d", code), cn,
                 exp_us(code, 1) * DIV, exp_us(code, 1) * DIV + 2);
         chk_rng($sformatf("R5 settle code %0d", code), co,
                 exp_us(code, 0) * DIV, exp_us(code, 0) * DIV + 2);
         repeat (8) @(negedge clk);
      end

      // R6 / R7 / R8 / R9 averaging sweep
      for (int n = 0; n <= 7; n++) begin
         base = 16'hF000 - n * 777; step = 16'h0123 + n * 17;
         setup(8'h80 | 8'(n), 8'h10 + 8'(n), 8'h00);
         sidx = 0; err_at = -1;
         wr(8'h47, 8'h80);
         chk("R13 chan latched", chan_n, 8'h10 + n);
         rd(8'h08, vn, vo); chk($sformatf("R8 pending n=%0d", n), vn, 8'h02);
         wait_irq(seen);
         chk("R9 irq seen", seen, 1);
         @(negedge clk); chk("R9 irq one cycle", irq_n, 0);
         rd(8'h08, vn, vo); chk($sformatf("R8 done n=%0d", n), vn, 8'h01);
         sum = 0;
         for (int k = 0; k < (1 << n); k++) sum += val(k);
         expv = sum >> n;
         read_result(res);
         chk($sformatf("R6 R7 average n=%0d", n), res, expv);
      end

      // R6 averaging disabled: count code ignored, single sample
      base = 16'h8421; step = 16'h1111;
      setup(8'h07, 8'h22, 8'h00);
      sidx = 0;
      wr(8'h47, 8'h80);
      wait_irq(seen);
      read_result(res); chk("R6 single sample", res, 16'h8421);
      prev = res;

      // R11 error mid-run, then error on the final sample
      base = 16'h0300; step = 5;
      setup(8'h83, 8'h05, 8'h00);
      sidx = 0; err_at = 3;
      wr(8'h47, 8'h80);
      wait_irq(seen);
      rd(8'h08, vn, vo); chk("R11 fault mid-run", vn, 8'h80);
      read_result(res);  chk("R11 result kept mid-run", res, prev);
      sidx = 0; err_at = 7;
      wr(8'h47, 8'h80);
      wait_irq(seen);
      rd(8'h08, vn, vo); chk("R11 fault on last sample", vn, 8'h80);
      read_result(res);  chk("R11 result kept on last", res, prev);
      err_at = -1;

      // R12 / R13 request during settle, channel rewrite during run
      base = 16'h4000; step = 2;
      setup(8'h80, 8'h5A, 8'h04);
      sidx = 0;
      wr(8'h47, 8'h80);
      c = 0;
      repeat (100) begin @(negedge clk); c++; end
      wr(8'h44, 8'h3C); c += 2;
      chk("R13 chan held", chan_n, 8'h5A);
      wr(8'h47, 8'h80); c += 2;
      while (!req_n && c < 5000) begin @(negedge clk); c++; end
      chk_rng("R12 settle not restarted", c, 400 * DIV, 400 * DIV + 2);
      wait_irq(seen);
      rd(8'h08, vn, vo); chk("R8 fault cleared by new run", vn, 8'h01);
      rd(8'h44, vn, vo); chk("R13 register updated", vn, 8'h3C);
      read_result(res);  chk("R7 result after busy request", res, 16'h4000);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule